// File: doc/BRIEF.md
# Operand-Capturing Issue Queue for One Execution Unit

This block holds operations that have been issued to one class of execution unit but may still be missing source operands. Every slot keeps, for each of its two sources, either the operand value itself or the tag of the producer that will deliver it. A single result bus is snooped every cycle. When a producer tag shows up on that bus, each slot waiting on that tag copies the broadcast value and marks the operand as present.

A slot whose two operands are both present competes for the execution unit. Each cycle one such slot is offered on a valid/ready dispatch port, and the oldest slot by allocation time is offered first. A slot is released when its offer is accepted. The `full` output tells the issue logic to hold back when no slot is free. A flush input empties the whole queue in one cycle, for example after a mispredicted branch.

The tag value zero is reserved to mean "operand present", so every producer tag is nonzero. A load or store keeps its address in each slot, and that address travels with the operation to dispatch.

Top module: `rs_station`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, so `full` is 0 and `disp_valid` is 0.
- R2: An operation issued with both source tags equal to 0 is offered on the dispatch port in the cycle after issue. The offer carries its op, both values, its destination tag and its address.
- R3: When `bc_valid` is 1 and `bc_tag` equals a slot's nonzero pending tag for a source, the slot stores `bc_val` as that source's value and marks the source present.
- R4: A slot is never offered for dispatch while either of its source tags is nonzero.
- R5: An issue in the same cycle as a broadcast whose tag equals one of the issued nonzero source tags captures the broadcast value in that cycle, so no wakeup is lost.
- R6: `full` is 1 exactly when all ENTRIES slots (default 4) are occupied. An issue presented while `full` is 1 is dropped and never appears at dispatch.
- R7: When more than one slot is ready, the offer goes to the slot that was allocated earliest, whatever its slot index.
- R8: While `disp_valid` is 1 and `disp_ready` is 0, the offer stays up and the slot is kept. The slot is freed only in a cycle where `disp_valid` and `disp_ready` are both 1.
- R9: `flush` empties every slot in one cycle. Broadcasts that arrive afterwards do not bring back any flushed operation.
- R10: A broadcast with tag 0, or with a tag that no pending source waits on, changes no stored operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties every slot |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_vj | input | DATA_W | First source value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | First source producer tag, 0 = present |
| iss_vk | input | DATA_W | Second source value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | Second source producer tag, 0 = present |
| iss_dest | input | TAG_W | Tag under which the result will be broadcast |
| iss_addr | input | ADDR_W | Memory address for loads and stores |
| full | output | 1 | All slots occupied; issue must wait |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Execution unit accepts the offer |
| disp_op | output | OP_W | Offered operation code |
| disp_vj | output | DATA_W | Offered first operand |
| disp_vk | output | DATA_W | Offered second operand |
| disp_dest | output | TAG_W | Offered destination tag |
| disp_addr | output | ADDR_W | Offered address |

## Verification
The hardest case to reach is two ready slots where the older one sits at the higher index. The stimulus fills slot 0 with a ready operation and slot 1 with one that waits on a tag. It then dispatches slot 0 and refills it with a younger ready operation, and only then releases slot 1 with a broadcast. The lost-wakeup case is reached by driving the issue and the matching broadcast in the same cycle. The full case is reached by parking four operations on one tag and then waking them all with a single broadcast.

// File: rtl/rs_pkg.sv
package rs_pkg;
    // Default sizing shared by the queue and its bench.
    localparam int unsigned RS_ENTRIES = 4;
    localparam int unsigned RS_DATA_W  = 32;
    localparam int unsigned RS_TAG_W   = 4;
    localparam int unsigned RS_OP_W    = 4;
    localparam int unsigned RS_ADDR_W  = 16;

    // Reserved tag meaning the operand value is already held.
    localparam int unsigned RS_TAG_NONE = 0;
endpackage

// File: rtl/rs_slot.sv
// rs_slot: one queue slot. Holds op, address, destination tag and, per source,
// a value plus a pending producer tag (0 = value present). Snoops the result
// bus while occupied and also when being allocated.
// Assumes alloc only targets an empty slot and release only an occupied, ready one.
module rs_slot #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic              release_i,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_vj,
    input  logic [TAG_W-1:0]  in_qj,
    input  logic [DATA_W-1:0] in_vk,
    input  logic [TAG_W-1:0]  in_qk,
    input  logic [TAG_W-1:0]  in_dest,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk,
    output logic [TAG_W-1:0]  dest,
    output logic [ADDR_W-1:0] addr
);
    logic [TAG_W-1:0] qj, qk;
    logic cap_j, cap_k, wake_j, wake_k;

    // Broadcast matches for an incoming issue and for the held sources.
    always_comb begin
        cap_j  = bc_valid && (in_qj != '0) && (in_qj == bc_tag);
        cap_k  = bc_valid && (in_qk != '0) && (in_qk == bc_tag);
        wake_j = busy && bc_valid && (qj != '0) && (qj == bc_tag);
        wake_k = busy && bc_valid && (qk != '0) && (qk == bc_tag);
    end

    assign ready = busy && (qj == '0) && (qk == '0);

    // Slot state: reset/flush, allocation with capture, wakeup and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            op   <= '0;
            vj   <= '0;
            vk   <= '0;
            qj   <= '0;
            qk   <= '0;
            dest <= '0;
            addr <= '0;
        end else if (flush) begin
            busy <= 1'b0;
        end else if (alloc) begin
            busy <= 1'b1;
            op   <= in_op;
            dest <= in_dest;
            addr <= in_addr;
            vj   <= cap_j ? bc_val : in_vj;
            qj   <= cap_j ? '0 : in_qj;
            vk   <= cap_k ? bc_val : in_vk;
            qk   <= cap_k ? '0 : in_qk;
        end else begin
            if (wake_j) begin
                vj <= bc_val;
                qj <= '0;
            end
            if (wake_k) begin
                vk <= bc_val;
                qk <= '0;
            end
            if (release_i) busy <= 1'b0;
        end
    end

    AST_WAKE_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !alloc && wake_j) |=> (qj == '0 && vj == $past(bc_val))); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !busy); // R9
    AST_KEPT_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush && !release_i) |=> busy); // R8
endmodule

// File: rtl/rs_age_pick.sv
// rs_age_pick: grants the oldest ready slot. An age matrix records, for every
// pair of slots, which one was allocated earlier. Assumes alloc_vec is one-hot or zero.
module rs_age_pick #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_vec,
    input  logic [N-1:0] ready_vec,
    output logic [N-1:0] grant
);
    // older[a][b] = 1 means slot a was allocated before slot b.
    logic [N-1:0] older [N];

    // Age matrix update: a new slot is younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < N; a++) older[a] <= '0;
        end else begin
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    if (alloc_vec[a] && a != b) older[a][b] <= 1'b0;
                    else if (alloc_vec[b] && a != b) older[a][b] <= 1'b1;
                end
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_grant
            logic [N-1:0] beats_me;
            // Ready slots that are older than slot gi.
            always_comb begin
                for (int a = 0; a < N; a++) beats_me[a] = ready_vec[a] && older[a][gi];
            end
            assign grant[gi] = ready_vec[gi] && (beats_me == '0);
        end
    endgenerate

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_GRANT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_vec != '0) |-> (grant != '0)); // R7
endmodule

// File: rtl/rs_station.sv
// rs_station: queue of ENTRIES slots feeding one execution unit. Allocates the
// lowest free slot on issue, snoops the result bus and offers the oldest ready
// slot on a valid/ready port. Assumes producer tags are nonzero.
module rs_station #(
    parameter int unsigned ENTRIES = rs_pkg::RS_ENTRIES,
    parameter int unsigned DATA_W  = rs_pkg::RS_DATA_W,
    parameter int unsigned TAG_W   = rs_pkg::RS_TAG_W,
    parameter int unsigned OP_W    = rs_pkg::RS_OP_W,
    parameter int unsigned ADDR_W  = rs_pkg::RS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [TAG_W-1:0]  iss_dest,
    input  logic [ADDR_W-1:0] iss_addr,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk,
    output logic [TAG_W-1:0]  disp_dest,
    output logic [ADDR_W-1:0] disp_addr
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] busy_vec, ready_vec, alloc_vec, grant_vec, release_vec;
    logic [OP_W-1:0]    s_op   [ENTRIES];
    logic [DATA_W-1:0]  s_vj   [ENTRIES];
    logic [DATA_W-1:0]  s_vk   [ENTRIES];
    logic [TAG_W-1:0]   s_dest [ENTRIES];
    logic [ADDR_W-1:0]  s_addr [ENTRIES];
    logic [IDX_W-1:0]   free_idx;
    logic               accept;

    assign full   = &busy_vec;
    assign accept = iss_valid && !full && !flush;

    // Lowest-index empty slot receives the next issue.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy_vec[i]) free_idx = IDX_W'(i);
        end
    end

    // One-hot allocate strobe and release on an accepted offer.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            alloc_vec[i]   = accept && (free_idx == IDX_W'(i));
            release_vec[i] = grant_vec[i] && disp_ready;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
            rs_slot #(
                .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .ADDR_W(ADDR_W)
            ) slot_i (
                .clk(clk), .rst_n(rst_n), .flush(flush),
                .alloc(alloc_vec[gi]), .release_i(release_vec[gi]),
                .in_op(iss_op), .in_vj(iss_vj), .in_qj(iss_qj),
                .in_vk(iss_vk), .in_qk(iss_qk), .in_dest(iss_dest), .in_addr(iss_addr),
                .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
                .busy(busy_vec[gi]), .ready(ready_vec[gi]),
                .op(s_op[gi]), .vj(s_vj[gi]), .vk(s_vk[gi]),
                .dest(s_dest[gi]), .addr(s_addr[gi])
            );
        end
    endgenerate

    rs_age_pick #(.N(ENTRIES)) pick_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_vec(alloc_vec), .ready_vec(ready_vec), .grant(grant_vec)
    );

    // Dispatch mux: OR together the fields of the single granted slot.
    always_comb begin
        disp_op   = '0;
        disp_vj   = '0;
        disp_vk   = '0;
        disp_dest = '0;
        disp_addr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant_vec[i]) begin
                disp_op   = disp_op   | s_op[i];
                disp_vj   = disp_vj   | s_vj[i];
                disp_vk   = disp_vk   | s_vk[i];
                disp_dest = disp_dest | s_dest[i];
                disp_addr = disp_addr | s_addr[i];
            end
        end
    end

    assign disp_valid = |grant_vec;

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !flush) |=> disp_valid); // R8
    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !disp_ready) |=> (full || $past(flush))); // R6
endmodule

// File: tb/rs_station_tb_top.sv
`timescale 1ns/1ps
module rs_station_tb_top;
    localparam int unsigned DW = 32, TW = 4, OW = 4, AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic iss_valid = 1'b0;
    logic [OW-1:0] iss_op = '0;
    logic [DW-1:0] iss_vj = '0, iss_vk = '0;
    logic [TW-1:0] iss_qj = '0, iss_qk = '0, iss_dest = '0;
    logic [AW-1:0] iss_addr = '0;
    logic full;
    logic bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_val = '0;
    logic disp_valid;
    logic disp_ready = 1'b0;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_vj, disp_vk;
    logic [TW-1:0] disp_dest;
    logic [AW-1:0] disp_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rs_station dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
        .iss_vk(iss_vk), .iss_qk(iss_qk), .iss_dest(iss_dest), .iss_addr(iss_addr),
        .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_dest(disp_dest), .disp_addr(disp_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to 1 ns after the next rising edge; drive and sample there.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [OW-1:0] op, input logic [DW-1:0] vj, input logic [TW-1:0] qj,
                         input logic [DW-1:0] vk, input logic [TW-1:0] qk,
                         input logic [TW-1:0] dest, input logic [AW-1:0] addr);
        iss_valid = 1; iss_op = op; iss_vj = vj; iss_qj = qj;
        iss_vk = vk; iss_qk = qk; iss_dest = dest; iss_addr = addr;
        cyc();
        iss_valid = 0;
    endtask

    task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] val);
        bc_valid = 1; bc_tag = tag; bc_val = val;
        cyc();
        bc_valid = 0;
    endtask

    task automatic take();
        disp_ready = 1;
        cyc();
        disp_ready = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        cyc();
        flush = 0;
    endtask

    task automatic t_reset();
        check(full == 0, "R1 full", full, 0);
        check(disp_valid == 0, "R1 disp_valid", disp_valid, 0);
    endtask

    task automatic t_ready_issue();
        issue(4'h3, 32'hA1, 0, 32'hB2, 0, 4'h9, 16'h1234);
        check(disp_valid == 1, "R2 valid", disp_valid, 1);
        check(disp_op == 4'h3 && disp_dest == 4'h9, "R2 op/dest", {disp_op, disp_dest}, 8'h39);
        check(disp_vj == 32'hA1 && disp_vk == 32'hB2, "R2 values", {disp_vj, disp_vk}, {32'hA1, 32'hB2});
        check(disp_addr == 16'h1234, "R2 addr", disp_addr, 16'h1234);
        cyc(); cyc();
        check(disp_valid == 1 && disp_op == 4'h3, "R8 offer held", disp_valid, 1);
        take();
        check(disp_valid == 0, "R8 freed on handshake", disp_valid, 0);
    endtask

    task automatic t_wakeup();
        issue(4'h5, 0, 4'h5, 0, 4'h6, 4'h1, 16'h0);
        check(disp_valid == 0, "R4 both pending", disp_valid, 0);
        bcast(4'h5, 32'h55);
        check(disp_valid == 0, "R4 one pending", disp_valid, 0);
        bcast(4'h6, 32'h66);
        check(disp_valid == 1, "R3 woke", disp_valid, 1);
        check(disp_vj == 32'h55 && disp_vk == 32'h66, "R3 captured", {disp_vj, disp_vk}, {32'h55, 32'h66});
        take();
    endtask

    task automatic t_same_cycle();
        bc_valid = 1; bc_tag = 4'h3; bc_val = 32'hC0DE;
        issue(4'h7, 0, 4'h3, 32'h9, 0, 4'h2, 16'h0);
        bc_valid = 0;
        check(disp_valid == 1, "R5 not lost", disp_valid, 1);
        check(disp_vj == 32'hC0DE, "R5 value", disp_vj, 32'hC0DE);
        take();
    endtask

    task automatic t_full();
        int got;
        for (int i = 0; i < 4; i++) issue(OW'(4 + i), 0, 4'hA, 0, 4'hA, 4'h1, 16'h0);
        check(full == 1, "R6 full set", full, 1);
        check(disp_valid == 0, "R4 all pending", disp_valid, 0);
        issue(4'hF, 1, 0, 1, 0, 4'h1, 16'h0);
        bcast(4'hA, 32'h1);
        got = 0;
        for (int i = 0; i < 5; i++) begin
            if (disp_valid) begin
                check(disp_op == OW'(4 + got), "R7 fill order", disp_op, 4 + got);
                got++;
            end
            take();
        end
        check(got == 4, "R6 dropped issue", got, 4);
        check(full == 0 && disp_valid == 0, "R6 drained", {full, disp_valid}, 0);
    endtask

    task automatic t_oldest();
        issue(4'h1, 1, 0, 1, 0, 4'h1, 16'h0);
        issue(4'h2, 0, 4'h9, 2, 0, 4'h1, 16'h0);
        check(disp_op == 4'h1, "R7 first", disp_op, 1);
        take();
        issue(4'h3, 3, 0, 3, 0, 4'h1, 16'h0);
        bcast(4'h9, 32'h99);
        check(disp_op == 4'h2, "R7 older high index", disp_op, 2);
        take();
        check(disp_op == 4'h3 && disp_valid == 1, "R7 younger next", disp_op, 3);
        take();
    endtask

    task automatic t_flush();
        issue(4'h8, 0, 4'hB, 0, 0, 4'h1, 16'h0);
        issue(4'h9, 5, 0, 5, 0, 4'h1, 16'h0);
        check(disp_valid == 1, "R9 pre", disp_valid, 1);
        do_flush();
        check(full == 0 && disp_valid == 0, "R9 empty", {full, disp_valid}, 0);
        bcast(4'hB, 32'h1);
        check(disp_valid == 0, "R9 no revival", disp_valid, 0);
    endtask

    task automatic t_ignore();
        issue(4'hA, 32'h11, 0, 32'h22, 0, 4'h1, 16'h0);
        issue(4'hB, 0, 4'hD, 32'h33, 0, 4'h1, 16'h0);
        bcast(4'h0, 32'hDEAD);
        bcast(4'hC, 32'hBEEF);
        check(disp_op == 4'hA && disp_vj == 32'h11 && disp_vk == 32'h22, "R10 tag0", disp_vj, 32'h11);
        take();
        check(disp_valid == 0, "R10 nonmatching", disp_valid, 0);
        bcast(4'hD, 32'h77);
        check(disp_valid == 1 && disp_vj == 32'h77 && disp_vk == 32'h33, "R3 late wake", disp_vj, 32'h77);
        take();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_ready_issue();
        t_wakeup();
        t_same_cycle();
        t_full();
        t_oldest();
        t_flush();
        t_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule